// File: doc/BRIEF.md
# Two-Pass Global Tone Mapping Engine

This block compresses the brightness range of one stored 8-bit grayscale frame. It makes two passes over a frame memory. In the first pass it reads every pixel and adds up a logarithmic code for each one. The mean of those codes gives a geometric-mean scene luminance, which the block shows on `lum_avg`. In the second pass it reads every pixel again. It scales each pixel by a fixed key over that mean luminance, compresses the result with a curve of the form L/(1+L), and writes the mapped value to a result memory at the same address.

The block has no divider, no processor and no arithmetic logarithm or exponential. Three parts stand in for them:

- The logarithm is a chain of range comparisons against constant thresholds.
- The mean of the codes is a multiply by a fixed reciprocal of the pixel count.
- The division by the average and the compression curve are two small constant tables.

With the key fixed, the mapped value depends only on the pixel and on the 8-bit average. A controller pulses `start` and then waits for `pix_done`.

Top module: `tone_map_engine`

## Requirements
- R1: After reset, `img_done`, `pix_done`, `frm_rd_en`, `res_wr_en` and `lum_avg` are all 0.
- R2: Each pass reads every address 0 to N-1 (N = 6348) once, in ascending order, one read per cycle, so there are 2N reads per frame. Read data is used one cycle after the address. If `start` is sampled at clock edge s, `img_done` is first high after edge s+N+2.
- R3: The log code of pixel p is the largest k in 0..48 with (p+1)*256 >= E(k). Here E(k) = C[k mod 6] << (k div 6) and C = {256, 287, 323, 362, 406, 456}.
- R4: The first pass accumulates the N log codes without overflow into a sum S. The mean code is M = min(48, (S*2643 + 2^23) >> 24).
- R5: `lum_avg` = min(255, ((E(M) + 128) >> 8) - 1). It updates when `img_done` rises.
- R6: Take a = `lum_avg`, R(a) = 65536 div max(a,1), and key 46/256. The scaled luminance of pixel p is Ls = min(255, (p*46*R(a)) >> 20), in units of 1/16.
- R7: The written value is (255*Ls + (16+Ls) div 2) div (16+Ls).
- R8: The second pass starts only after `img_done`. It writes every address 0 to N-1 once, in ascending order, each address carrying the mapped value of the pixel read there. `pix_done` is first high together with the final write, after edge s+2N+3.
- R9: A `start` pulse while either pass is running has no effect on the reads, the writes or the timing of the done flags.
- R10: `img_done`, `pix_done` and `lum_avg` hold after a frame ends. A new `start` clears both done flags at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a frame; accepted only when idle |
| frm_rd_en | output | 1 | Frame memory read strobe |
| frm_rd_addr | output | 13 | Frame memory read address |
| frm_rd_data | input | 8 | Frame memory data, one cycle after the address |
| res_wr_en | output | 1 | Result memory write strobe |
| res_wr_addr | output | 13 | Result memory write address |
| res_wr_data | output | 8 | Mapped pixel value |
| lum_avg | output | 8 | Log-average luminance from the first pass |
| img_done | output | 1 | First pass complete (sticky) |
| pix_done | output | 1 | Second pass complete (sticky) |

## Verification
Every cycle, the assertions check these properties:

- Read and write addresses step by one within a burst.
- No write appears before the first pass has finished.
- `pix_done` never stands without `img_done`.
- A done flag falls only after a start.
- The log sum never wraps.

Only the bench's frames can show the numeric content: the comparator-chain logarithm, the rounded mean, the inverse table and the compression curve on constant, ramp and scrambled images. The same holds for the exact cycles of the done flags and for a start pulse during a pass being ignored.

// File: rtl/tmo_pkg.sv
package tmo_pkg;

    localparam int OCT_STEPS = 6;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_IMG,
        ST_MEAN,
        ST_PIX
    } tmo_state_e;

    // 2^(k/6) in Q8
    function automatic int exp_q8(input int k);
        int base;
        case (k % OCT_STEPS)
            0:       base = 256;
            1:       base = 287;
            2:       base = 323;
            3:       base = 362;
            4:       base = 406;
            default: base = 456;
        endcase
        return base << (k / OCT_STEPS);
    endfunction

    function automatic int avg_of_code(input int m, input int maxv);
        int v;
        v = ((exp_q8(m) + 128) >> 8) - 1;
        return (v > maxv) ? maxv : v;
    endfunction

    function automatic int rcp_q16(input int a);
        return (a == 0) ? 65536 : 65536 / a;
    endfunction

    function automatic int curve_val(input int i, input int knee, input int maxv);
        return (maxv * i + (knee + i) / 2) / (knee + i);
    endfunction

endpackage

// File: rtl/tmo_log_chain.sv
module tmo_log_chain #(
    parameter int PIX_W   = 8,
    parameter int LOG_MAX = 48,
    parameter int LOG_W   = 6
) (
    input  logic [PIX_W-1:0] pix,
    output logic [LOG_W-1:0] code
);
    localparam int LW = PIX_W + 9;

    logic [LW-1:0]      lum_q8;
    logic [LOG_MAX:1]   hit;

    assign lum_q8 = (LW'(pix) + LW'(1)) << 8;

    for (genvar k = 1; k <= LOG_MAX; k++) begin : g_thr
        localparam int THR = tmo_pkg::exp_q8(k);
        assign hit[k] = (lum_q8 >= LW'(THR));
    end

    // priority chain: highest passed threshold wins
    always_comb begin
        code = '0;
        for (int k = 1; k <= LOG_MAX; k++) begin
            if (hit[k]) code = LOG_W'(k);
        end
    end

endmodule

// File: rtl/tmo_log_avg.sv
module tmo_log_avg #(
    parameter int PIX_W   = 8,
    parameter int NUM_PIX = 6348,
    parameter int LOG_MAX = 48,
    parameter int LOG_W   = 6,
    parameter int ACC_W   = 19
) (
    input  logic [ACC_W-1:0] acc,
    output logic [PIX_W-1:0] avg
);
    localparam int MEAN_SH  = 24;
    localparam longint MEAN_RCP = ((64'd1 << MEAN_SH) + NUM_PIX - 1) / NUM_PIX;
    localparam int MAXV     = (1 << PIX_W) - 1;

    logic [63:0]        prod;
    logic [63:0]        mean_full;
    logic [LOG_W-1:0]   mean;
    logic [PIX_W-1:0]   avg_tbl [LOG_MAX+1];

    for (genvar m = 0; m <= LOG_MAX; m++) begin : g_inv
        assign avg_tbl[m] = PIX_W'(tmo_pkg::avg_of_code(m, MAXV));
    end

    always_comb begin
        prod      = 64'(acc) * 64'(MEAN_RCP) + (64'd1 << (MEAN_SH - 1));
        mean_full = prod >> MEAN_SH;
        mean      = (mean_full > 64'(LOG_MAX)) ? LOG_W'(LOG_MAX) : LOG_W'(mean_full);
        avg       = avg_tbl[mean];
    end

endmodule

// File: rtl/tmo_tone_curve.sv
module tmo_tone_curve #(
    parameter int PIX_W   = 8,
    parameter int KEY_Q8  = 46,
    parameter int LS_FRAC = 4
) (
    input  logic [PIX_W-1:0] pix,
    input  logic [PIX_W-1:0] avg,
    output logic [PIX_W-1:0] mapped
);
    localparam int NV    = 1 << PIX_W;
    localparam int MAXV  = NV - 1;
    localparam int SH    = 8 + 16 - LS_FRAC;
    localparam int KNEE  = 1 << LS_FRAC;

    logic [16:0]        rcp_tbl [NV];
    logic [PIX_W-1:0]   crv_tbl [NV];
    logic [31:0]        prod;
    logic [31:0]        ls_full;
    logic [PIX_W-1:0]   ls;

    for (genvar a = 0; a < NV; a++) begin : g_tbl
        assign rcp_tbl[a] = 17'(tmo_pkg::rcp_q16(a));
        assign crv_tbl[a] = PIX_W'(tmo_pkg::curve_val(a, KNEE, MAXV));
    end

    always_comb begin
        prod    = 32'(pix) * 32'(KEY_Q8) * 32'(rcp_tbl[avg]);
        ls_full = prod >> SH;
        ls      = (ls_full > 32'(MAXV)) ? PIX_W'(MAXV) : PIX_W'(ls_full);
        mapped  = crv_tbl[ls];
    end

endmodule

// File: rtl/tone_map_engine.sv
module tone_map_engine #(
    parameter int PIX_W   = 8,
    parameter int NUM_PIX = 6348,
    parameter int KEY_Q8  = 46,
    parameter int LS_FRAC = 4,
    localparam int ADDR_W  = $clog2(NUM_PIX),
    localparam int LOG_MAX = tmo_pkg::OCT_STEPS * PIX_W,
    localparam int LOG_W   = $clog2(LOG_MAX + 1),
    localparam int ACC_W   = $clog2(LOG_MAX * NUM_PIX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              frm_rd_en,
    output logic [ADDR_W-1:0] frm_rd_addr,
    input  logic [PIX_W-1:0]  frm_rd_data,
    output logic              res_wr_en,
    output logic [ADDR_W-1:0] res_wr_addr,
    output logic [PIX_W-1:0]  res_wr_data,
    output logic [PIX_W-1:0]  lum_avg,
    output logic              img_done,
    output logic              pix_done
);
    import tmo_pkg::*;

    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NUM_PIX - 1);

    typedef struct packed {
        tmo_state_e        st;
        logic              rd_en;
        logic [ADDR_W-1:0] rd_addr;
        logic              vld;
        logic [ADDR_W-1:0] tag;
        logic [ACC_W-1:0]  acc;
        logic [PIX_W-1:0]  avg;
        logic              img_done;
        logic              pix_done;
        logic              wr_en;
        logic [ADDR_W-1:0] wr_addr;
        logic [PIX_W-1:0]  wr_data;
    } regs_t;

    regs_t r_d, r_q;

    logic [LOG_W-1:0]  log_code;
    logic [PIX_W-1:0]  avg_calc;
    logic [PIX_W-1:0]  mapped;

    tmo_log_chain #(.PIX_W(PIX_W), .LOG_MAX(LOG_MAX), .LOG_W(LOG_W)) u_log (
        .pix  (frm_rd_data),
        .code (log_code)
    );

    tmo_log_avg #(.PIX_W(PIX_W), .NUM_PIX(NUM_PIX), .LOG_MAX(LOG_MAX),
                  .LOG_W(LOG_W), .ACC_W(ACC_W)) u_avg (
        .acc (r_q.acc),
        .avg (avg_calc)
    );

    tmo_tone_curve #(.PIX_W(PIX_W), .KEY_Q8(KEY_Q8), .LS_FRAC(LS_FRAC)) u_curve (
        .pix    (frm_rd_data),
        .avg    (r_q.avg),
        .mapped (mapped)
    );

    always_comb begin
        r_d       = r_q;
        r_d.vld   = r_q.rd_en;
        r_d.tag   = r_q.rd_addr;
        r_d.wr_en = 1'b0;

        // address issue: one per cycle until the last pixel
        if (r_q.rd_en) begin
            if (r_q.rd_addr == LAST) begin
                r_d.rd_en = 1'b0;
            end else begin
                r_d.rd_addr = r_q.rd_addr + ADDR_W'(1);
            end
        end

        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st       = ST_IMG;
                    r_d.rd_en    = 1'b1;
                    r_d.rd_addr  = '0;
                    r_d.acc      = '0;
                    r_d.img_done = 1'b0;
                    r_d.pix_done = 1'b0;
                end
            end
            ST_IMG: begin
                if (r_q.vld) begin
                    r_d.acc = r_q.acc + ACC_W'(log_code);
                    if (r_q.tag == LAST) r_d.st = ST_MEAN;
                end
            end
            ST_MEAN: begin
                r_d.avg      = avg_calc;
                r_d.img_done = 1'b1;
                r_d.st       = ST_PIX;
                r_d.rd_en    = 1'b1;
                r_d.rd_addr  = '0;
            end
            default: begin
                r_d.wr_en   = r_q.vld;
                r_d.wr_addr = r_q.tag;
                r_d.wr_data = mapped;
                if (r_q.vld && r_q.tag == LAST) begin
                    r_d.pix_done = 1'b1;
                    r_d.st       = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign frm_rd_en   = r_q.rd_en;
    assign frm_rd_addr = r_q.rd_addr;
    assign res_wr_en   = r_q.wr_en;
    assign res_wr_addr = r_q.wr_addr;
    assign res_wr_data = r_q.wr_data;
    assign lum_avg     = r_q.avg;
    assign img_done    = r_q.img_done;
    assign pix_done    = r_q.pix_done;

    // R2
    rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_rd_en && $past(frm_rd_en)) |-> frm_rd_addr == $past(frm_rd_addr) + ADDR_W'(1));

    // R8
    wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_wr_en && $past(res_wr_en)) |-> res_wr_addr == $past(res_wr_addr) + ADDR_W'(1));

    // R8
    wr_after_img_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_wr_en |-> img_done);

    // R8
    done_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_done |-> img_done);

    // R10
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(img_done) || $fell(pix_done)) |-> $past(start));

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IMG && r_q.vld) |=> r_q.acc >= $past(r_q.acc));

endmodule

// File: tb/tone_map_engine_bench.sv
module tone_map_engine_bench;
    localparam int N      = 6348;
    localparam int AW     = 13;
    localparam int NPAT   = 6;
    // [11:8] mode (0 const, 1 ramp, 2 scrambled), [7:0] seed
    localparam logic [11:0] PATS [NPAT] = '{12'h000, 12'h0FF, 12'h101,
                                            12'h25B, 12'h099, 12'h203};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          frm_rd_en;
    logic [AW-1:0] frm_rd_addr;
    logic [7:0]    frm_rd_data;
    logic          res_wr_en;
    logic [AW-1:0] res_wr_addr;
    logic [7:0]    res_wr_data;
    logic [7:0]    lum_avg;
    logic          img_done;
    logic          pix_done;

    logic [7:0] frame   [N];
    int         exp_out [N];
    int         cyc = 0;
    int         n_chk = 0;
    int         n_fail = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(posedge clk) if (frm_rd_en) frm_rd_data <= frame[frm_rd_addr];

    tone_map_engine u_tone_map_engine (
        .clk, .rst_n, .start, .frm_rd_en, .frm_rd_addr, .frm_rd_data,
        .res_wr_en, .res_wr_addr, .res_wr_data, .lum_avg, .img_done, .pix_done
    );

    function automatic int e_q8(input int k);
        int c;
        case (k % 6)
            0: c = 256; 1: c = 287; 2: c = 323;
            3: c = 362; 4: c = 406; default: c = 456;
        endcase
        return c << (k / 6);
    endfunction

    function automatic int ref_code(input int p);
        int best = 0;
        for (int k = 1; k <= 48; k++) if ((p + 1) * 256 >= e_q8(k)) best = k;
        return best;
    endfunction

    function automatic int ref_avg(input longint s);
        longint m;
        int a;
        m = (s * 2643 + (64'd1 << 23)) >> 24;
        if (m > 48) m = 48;
        a = ((e_q8(int'(m)) + 128) >> 8) - 1;
        return (a > 255) ? 255 : a;
    endfunction

    function automatic int ref_map(input int p, input int a);
        int r, ls;
        r  = 65536 / ((a == 0) ? 1 : a);
        ls = (p * 46 * r) >> 20;
        if (ls > 255) ls = 255;
        return (255 * ls + (16 + ls) / 2) / (16 + ls);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_frame(input logic [11:0] pat, input bit inject);
        longint sum = 0;
        int a_exp, s, img_cyc, pix_cyc, rd_cnt, rd_err, wr_cnt, ord_err, dat_err;
        int bad_act, bad_exp, guard;
        bit cleared;
        for (int i = 0; i < N; i++) begin
            case (pat[11:8])
                4'd0:    frame[i] = pat[7:0];
                4'd1:    frame[i] = 8'((i * pat[7:0]) % 256);
                default: frame[i] = 8'(((i * 37) ^ ((i >> 5) * pat[7:0])) % 256);
            endcase
            sum += ref_code(frame[i]);
        end
        a_exp = ref_avg(sum);
        for (int i = 0; i < N; i++) exp_out[i] = ref_map(frame[i], a_exp);

        img_cyc = -1; pix_cyc = -1; rd_cnt = 0; rd_err = 0; wr_cnt = 0;
        ord_err = 0; dat_err = 0; bad_act = 0; bad_exp = 0; guard = 0;
        @(negedge clk) start = 1'b1;
        s = cyc + 1;
        @(negedge clk) start = 1'b0;
        cleared = !img_done && !pix_done;
        while (pix_cyc < 0 && guard < 3 * N + 50) begin
            start = inject && (cyc == s + 40 || cyc == s + N + 100);
            if (frm_rd_en) begin
                if (int'(frm_rd_addr) != rd_cnt % N) rd_err++;
                rd_cnt++;
            end
            if (res_wr_en) begin
                if (!img_done || int'(res_wr_addr) != wr_cnt) ord_err++;
                if (int'(res_wr_addr) < N && int'(res_wr_data) != exp_out[res_wr_addr]) begin
                    if (dat_err == 0) begin
                        bad_act = res_wr_data; bad_exp = exp_out[res_wr_addr];
                    end
                    dat_err++;
                end
                wr_cnt++;
            end
            if (img_done && img_cyc < 0) img_cyc = cyc;
            if (pix_done) pix_cyc = cyc;
            guard++;
            @(negedge clk);
        end
        start = 1'b0;
        chk(cleared, "R10 start clears done flags", 0, 0);
        chk(int'(lum_avg) == a_exp, "R3 R4 R5 log-average", lum_avg, a_exp);
        chk(img_cyc == s + N + 2, "R2 img_done cycle", img_cyc - s, N + 2);
        chk(rd_err == 0 && rd_cnt == 2 * N, "R2 read sequence", rd_cnt, 2 * N);
        chk(dat_err == 0, "R6 R7 mapped pixel", bad_act, bad_exp);
        chk(ord_err == 0 && wr_cnt == N, "R8 write order and count", wr_cnt, N);
        chk(pix_cyc == s + 2 * N + 3, "R8 pix_done cycle", pix_cyc - s, 2 * N + 3);
        if (inject) chk(pix_cyc == s + 2 * N + 3 && rd_cnt == 2 * N,
                        "R9 start during pass ignored", pix_cyc - s, 2 * N + 3);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        int held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(!img_done && !pix_done && !frm_rd_en && !res_wr_en && lum_avg == 0,
            "R1 reset state", {img_done, pix_done, frm_rd_en, res_wr_en}, 0);
        chk(lum_avg == 0, "R1 reset lum_avg", lum_avg, 0);

        for (int p = 0; p < NPAT; p++) begin
            run_frame(PATS[p], p == 3);
        end

        // R10: flags and average hold while idle
        held = lum_avg;
        repeat (25) @(negedge clk);
        chk(img_done && pix_done, "R10 done flags sticky", {img_done, pix_done}, 3);
        chk(int'(lum_avg) == held, "R10 lum_avg held", lum_avg, held);

        run_frame(12'h1FF, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule